// File: doc/BRIEF.md
# Predicated Instruction Decoder

This block takes one 32-bit instruction word for a small load/store core and turns it into a registered control bundle. The 6-bit opcode alone selects one of five operand layouts: three registers, two registers plus a short signed constant, two registers plus a short unsigned offset, three registers for base-plus-index addressing, or a single long signed constant. From that layout the block pulls out the register numbers and widens any constant to 32 bits. It also tags the instruction with a coarse class (ALU, load, store, branch, jump or trap) and flags opcodes that fall outside the defined set.

Every instruction carries a 4-bit predicate mask, and the block holds the 4-bit condition flags register that the mask is tested against. The instruction may execute only when each flag named in the mask is set. An empty mask always passes. The flags register is loaded through a dedicated write port, and the result of the test appears as an execute-enable in the bundle. Downstream stages use the bundle one cycle after the word is presented with `in_valid_i` high. Cycles without a valid word produce a non-executing bubble.

Top module: `pred_decode`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `out_valid_o`, `exec_o`, `illegal_o`, `dest_wr_o` and `flags_o` read zero until a word is accepted or the flags are written.
- R2: A word presented with `in_valid_i` high at a rising edge appears in the bundle after that edge with `out_valid_o` high. After an edge with `in_valid_i` low, `out_valid_o`, `exec_o` and `dest_wr_o` are low.
- R3: The opcode sits in instruction bits 27:22, and `mode_o` encodes the layout as 0 three-register, 1 register-immediate, 2 base-offset, 3 base-index, 4 immediate-only and 7 none. The layouts by opcode are as follows. Opcodes 0–9 use mode 0 when even and mode 1 when odd. Opcode 10 uses mode 0. Opcodes 11–16 use mode 0 when odd and mode 1 when even. Opcodes 17–28 use mode 2 when odd and mode 3 when even. Opcodes 29, 31 and 32 use mode 4, and opcode 30 uses mode 0.
- R4: Register fields are dest/target in bits 21:17, first source/base in 16:12 and second source/index in 11:7. A field that the layout or opcode does not use reads zero. This covers all three fields in mode 4, the second source in modes 1 and 2 and for opcode 10, and the destination and second source for opcode 30.
- R5: The register-immediate constant in bits 11:0 and the immediate-only constant in bits 21:0 are sign-extended as two's complement to 32 bits on `imm_o`.
- R6: The base-offset constant in bits 11:0 is zero-extended on `imm_o`. Modes 0 and 3 give `imm_o` = 0.
- R7: The mask is in bits 31:28 and `flags_o` is held as bit 3 carry, bit 2 negative, bit 1 zero, bit 0 positive. Instruction bit 28+k selects flag bit k. `exec_o` is high only if every selected flag is set, and a mask of 0000 always executes.
- R8: Opcodes 33–63 give `illegal_o` = 1, `exec_o` = 0, `mode_o` = 7 and `class_o` = 7.
- R9: When `flag_we_i` is high at an edge, `flags_o` takes `flag_d_i` after that edge and holds otherwise. A word accepted at the same edge is tested against the flags held before that edge.
- R10: `class_o` is 0 for opcodes 0–16, 1 for 17–22, 2 for 23–28, 3 for 29, 4 for 30–31 and 5 for 32.
- R11: `dest_wr_o` is high only when `exec_o` is high, the class is ALU or load, and the destination field is nonzero. Register 0 is a discard target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| flag_we_i | input | 1 | Load the flags register |
| flag_d_i | input | 4 | New flags value (C,N,Z,P from bit 3 down) |
| flags_o | output | 4 | Current flags register |
| out_valid_o | output | 1 | Bundle holds an accepted word |
| exec_o | output | 1 | Predicate passed and opcode legal |
| illegal_o | output | 1 | Opcode outside the defined set |
| dest_wr_o | output | 1 | Destination register will be written |
| mode_o | output | 3 | Operand layout code |
| class_o | output | 3 | Instruction class code |
| opcode_o | output | 6 | Opcode of the accepted word |
| rd_o | output | 5 | Destination / target register |
| rs1_o | output | 5 | First source / base register |
| rs2_o | output | 5 | Second source / index register |
| imm_o | output | 32 | Extended constant |

## Verification
A wrong flags register shows at the next accepted word as an `exec_o` that disagrees with its mask. The value also appears directly on `flags_o` one edge after the write. A wrong layout choice shows in the same bundle as a wrong `mode_o`, a register field that should be zero but is not, or a constant widened with the wrong sign. A bundle that fails to drop to a bubble shows as `out_valid_o` or `exec_o` still high one edge after an idle cycle, where a stale write enable would reach the register file.

// File: rtl/pred_decode_pkg.sv
package pred_decode_pkg;

  localparam int unsigned ILEN      = 32;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned COND_W    = 4;
  localparam int unsigned REG_W     = 5;
  localparam int unsigned OPND_W    = ILEN - OPC_W - COND_W;
  localparam int unsigned SHORT_W   = 12;
  localparam int unsigned COND_LSB  = ILEN - COND_W;
  localparam int unsigned OPC_LSB   = OPND_W;
  localparam int unsigned RD_LSB    = OPND_W - REG_W;
  localparam int unsigned RS1_LSB   = RD_LSB - REG_W;
  localparam int unsigned RS2_LSB   = RS1_LSB - REG_W;

  localparam int unsigned OPC_ALU_LAST   = 16;
  localparam int unsigned OPC_PARITY_SW  = 10;
  localparam int unsigned OPC_LOAD_LAST  = 22;
  localparam int unsigned OPC_MEM_LAST   = 28;
  localparam int unsigned OPC_BRANCH     = 29;
  localparam int unsigned OPC_JMP_REG    = 30;
  localparam int unsigned OPC_JMP_IMM    = 31;
  localparam int unsigned OPC_TRAP       = 32;

  typedef enum logic [2:0] {
    MODE_RRR  = 3'd0,
    MODE_RRI  = 3'd1,
    MODE_BOFF = 3'd2,
    MODE_BIDX = 3'd3,
    MODE_IMM  = 3'd4,
    MODE_NONE = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_BRANCH = 3'd3,
    CLS_JUMP   = 3'd4,
    CLS_TRAP   = 3'd5,
    CLS_NONE   = 3'd7
  } cls_e;

  typedef struct packed {
    logic              valid;
    logic              exec;
    logic              illegal;
    logic              dest_wr;
    mode_e             mode;
    cls_e              cls;
    logic [OPC_W-1:0]  opcode;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  rs1;
    logic [REG_W-1:0]  rs2;
    logic [XLEN-1:0]   imm;
  } bundle_t;

endpackage

// File: rtl/pd_mode_lut.sv
module pd_mode_lut
  import pred_decode_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output mode_e            mode_o,
  output cls_e             cls_o,
  output logic             illegal_o,
  output logic             rd_used_o,
  output logic             rs1_used_o,
  output logic             rs2_used_o
);

  logic [7:0] opc;
  assign opc = 8'(opcode_i);

  always_comb begin
    mode_o    = MODE_NONE;
    cls_o     = CLS_NONE;
    illegal_o = 1'b0;
    if (opc <= 8'(OPC_ALU_LAST)) begin
      cls_o = CLS_ALU;
      // parity meaning flips after the single-layout opcode
      if (opc < 8'(OPC_PARITY_SW))       mode_o = opc[0] ? MODE_RRI : MODE_RRR;
      else if (opc == 8'(OPC_PARITY_SW)) mode_o = MODE_RRR;
      else                               mode_o = opc[0] ? MODE_RRR : MODE_RRI;
    end else if (opc <= 8'(OPC_MEM_LAST)) begin
      cls_o  = (opc <= 8'(OPC_LOAD_LAST)) ? CLS_LOAD : CLS_STORE;
      mode_o = opc[0] ? MODE_BOFF : MODE_BIDX;
    end else if (opc == 8'(OPC_BRANCH)) begin
      cls_o  = CLS_BRANCH;
      mode_o = MODE_IMM;
    end else if (opc == 8'(OPC_JMP_REG)) begin
      cls_o  = CLS_JUMP;
      mode_o = MODE_RRR;
    end else if (opc == 8'(OPC_JMP_IMM)) begin
      cls_o  = CLS_JUMP;
      mode_o = MODE_IMM;
    end else if (opc == 8'(OPC_TRAP)) begin
      cls_o  = CLS_TRAP;
      mode_o = MODE_IMM;
    end else begin
      illegal_o = 1'b1;
    end
  end

  logic reg_layout;
  assign reg_layout = (mode_o == MODE_RRR) || (mode_o == MODE_RRI) ||
                      (mode_o == MODE_BOFF) || (mode_o == MODE_BIDX);

  assign rs1_used_o = reg_layout;
  assign rd_used_o  = reg_layout && (opc != 8'(OPC_JMP_REG));
  assign rs2_used_o = ((mode_o == MODE_RRR) || (mode_o == MODE_BIDX)) &&
                      (opc != 8'(OPC_PARITY_SW)) && (opc != 8'(OPC_JMP_REG));

endmodule

// File: rtl/pd_field_ext.sv
module pd_field_ext
  import pred_decode_pkg::*;
#(
  parameter int unsigned XW = XLEN,
  parameter int unsigned OW = OPND_W,
  parameter int unsigned SW = SHORT_W
) (
  input  logic [OW-1:0]    opnd_i,
  input  mode_e            mode_i,
  input  logic             rd_used_i,
  input  logic             rs1_used_i,
  input  logic             rs2_used_i,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o,
  output logic [XW-1:0]    imm_o
);

  localparam int unsigned RD_L  = OW - REG_W;
  localparam int unsigned RS1_L = RD_L - REG_W;
  localparam int unsigned RS2_L = RS1_L - REG_W;

  logic [XW-1:0] short_sx, short_zx, long_sx;

  generate
    if (XW > SW) begin : g_short
      assign short_sx = {{(XW-SW){opnd_i[SW-1]}}, opnd_i[SW-1:0]};
      assign short_zx = {{(XW-SW){1'b0}}, opnd_i[SW-1:0]};
    end else begin : g_short_trunc
      assign short_sx = opnd_i[XW-1:0];
      assign short_zx = opnd_i[XW-1:0];
    end
    if (XW > OW) begin : g_long
      assign long_sx = {{(XW-OW){opnd_i[OW-1]}}, opnd_i};
    end else begin : g_long_trunc
      assign long_sx = opnd_i[XW-1:0];
    end
  endgenerate

  assign rd_o  = rd_used_i  ? opnd_i[RD_L  +: REG_W] : '0;
  assign rs1_o = rs1_used_i ? opnd_i[RS1_L +: REG_W] : '0;
  assign rs2_o = rs2_used_i ? opnd_i[RS2_L +: REG_W] : '0;

  always_comb begin
    unique case (mode_i)
      MODE_RRI:  imm_o = short_sx;
      MODE_BOFF: imm_o = short_zx;
      MODE_IMM:  imm_o = long_sx;
      default:   imm_o = '0;
    endcase
  end

endmodule

// File: rtl/pd_cond_eval.sv
module pd_cond_eval
  import pred_decode_pkg::*;
#(
  parameter int unsigned NF = COND_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flag_we_i,
  input  logic [NF-1:0] flag_d_i,
  input  logic [NF-1:0] mask_i,
  output logic [NF-1:0] flags_o,
  output logic          pass_o
);

  logic [NF-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= '0;
    else if (flag_we_i) flags_q <= flag_d_i;
  end

  // every selected flag must be set; empty mask passes
  assign pass_o  = ~|(mask_i & ~flags_q);
  assign flags_o = flags_q;

endmodule

// File: rtl/pred_decode.sv
module pred_decode
  import pred_decode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ILEN-1:0]   instr_i,
  input  logic              flag_we_i,
  input  logic [COND_W-1:0] flag_d_i,
  output logic [COND_W-1:0] flags_o,
  output logic              out_valid_o,
  output logic              exec_o,
  output logic              illegal_o,
  output logic              dest_wr_o,
  output logic [2:0]        mode_o,
  output logic [2:0]        class_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rs1_o,
  output logic [REG_W-1:0]  rs2_o,
  output logic [XLEN-1:0]   imm_o
);

  logic [COND_W-1:0] mask;
  logic [OPC_W-1:0]  opc;
  logic [OPND_W-1:0] opnd;

  assign mask = instr_i[COND_LSB +: COND_W];
  assign opc  = instr_i[OPC_LSB  +: OPC_W];
  assign opnd = instr_i[OPND_W-1:0];

  mode_e            dec_mode;
  cls_e             dec_cls;
  logic             dec_ill, rd_used, rs1_used, rs2_used, pass;
  logic [REG_W-1:0] f_rd, f_rs1, f_rs2;
  logic [XLEN-1:0]  f_imm;

  pd_mode_lut u_lut (
    .opcode_i   (opc),
    .mode_o     (dec_mode),
    .cls_o      (dec_cls),
    .illegal_o  (dec_ill),
    .rd_used_o  (rd_used),
    .rs1_used_o (rs1_used),
    .rs2_used_o (rs2_used)
  );

  pd_field_ext #(.XW(XLEN), .OW(OPND_W), .SW(SHORT_W)) u_ext (
    .opnd_i     (opnd),
    .mode_i     (dec_mode),
    .rd_used_i  (rd_used),
    .rs1_used_i (rs1_used),
    .rs2_used_i (rs2_used),
    .rd_o       (f_rd),
    .rs1_o      (f_rs1),
    .rs2_o      (f_rs2),
    .imm_o      (f_imm)
  );

  pd_cond_eval #(.NF(COND_W)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_we_i (flag_we_i),
    .flag_d_i  (flag_d_i),
    .mask_i    (mask),
    .flags_o   (flags_o),
    .pass_o    (pass)
  );

  bundle_t d, q;
  logic    run;

  assign run = pass && !dec_ill;

  always_comb begin
    d.valid   = 1'b1;
    d.exec    = run;
    d.illegal = dec_ill;
    d.dest_wr = run && ((dec_cls == CLS_ALU) || (dec_cls == CLS_LOAD)) && (f_rd != '0);
    d.mode    = dec_mode;
    d.cls     = dec_cls;
    d.opcode  = opc;
    d.rd      = f_rd;
    d.rs1     = f_rs1;
    d.rs2     = f_rs2;
    d.imm     = f_imm;
  end

  // idle cycles only kill the qualifiers; payload flops keep their value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (in_valid_i) begin
      q <= d;
    end else begin
      q.valid   <= 1'b0;
      q.exec    <= 1'b0;
      q.dest_wr <= 1'b0;
    end
  end

  assign out_valid_o = q.valid;
  assign exec_o      = q.exec;
  assign illegal_o   = q.illegal;
  assign dest_wr_o   = q.dest_wr;
  assign mode_o      = q.mode;
  assign class_o     = q.cls;
  assign opcode_o    = q.opcode;
  assign rd_o        = q.rd;
  assign rs1_o       = q.rs1;
  assign rs2_o       = q.rs2;
  assign imm_o       = q.imm;

endmodule

// File: rtl/pred_decode_chk.sv
module pred_decode_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [31:0] instr_i,
  input logic        flag_we_i,
  input logic [3:0]  flag_d_i,
  input logic [3:0]  flags_o,
  input logic        out_valid_o,
  input logic        exec_o,
  input logic        illegal_o,
  input logic        dest_wr_o,
  input logic [2:0]  mode_o,
  input logic [4:0]  rd_o,
  input logic [31:0] imm_o
);

  assert_bubble_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && !exec_o && !dest_wr_o));

  assert_illegal_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && instr_i[27:22] > 6'd32) |=> (illegal_o && !exec_o));

  assert_empty_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && instr_i[31:28] == 4'd0 && instr_i[27:22] <= 6'd32) |=> exec_o);

  assert_flag_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (flags_o == $past(flag_d_i)));

  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  assert_dest_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_wr_o |-> (exec_o && rd_o != 5'd0));

  assert_offset_zext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_o == 3'd2) |-> (imm_o[31:12] == 20'd0));

endmodule

bind pred_decode pred_decode_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .instr_i     (instr_i),
  .flag_we_i   (flag_we_i),
  .flag_d_i    (flag_d_i),
  .flags_o     (flags_o),
  .out_valid_o (out_valid_o),
  .exec_o      (exec_o),
  .illegal_o   (illegal_o),
  .dest_wr_o   (dest_wr_o),
  .mode_o      (mode_o),
  .rd_o        (rd_o),
  .imm_o       (imm_o)
);

// File: tb/pred_decode_test.sv
module pred_decode_test;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        flag_we_i = 1'b0;
  logic [3:0]  flag_d_i = '0;
  logic [3:0]  flags_o;
  logic        out_valid_o, exec_o, illegal_o, dest_wr_o;
  logic [2:0]  mode_o, class_o;
  logic [5:0]  opcode_o;
  logic [4:0]  rd_o, rs1_o, rs2_o;
  logic [31:0] imm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pred_decode uut (
    .clk_i, .rst_ni, .in_valid_i, .instr_i, .flag_we_i, .flag_d_i, .flags_o,
    .out_valid_o, .exec_o, .illegal_o, .dest_wr_o, .mode_o, .class_o,
    .opcode_o, .rd_o, .rs1_o, .rs2_o, .imm_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [5:0] op, input logic [21:0] o);
    return {c, op, o};
  endfunction

  function automatic logic [21:0] regs(input logic [4:0] a, input logic [4:0] b, input logic [11:0] t);
    return {a, b, t};
  endfunction

  // present one word, bundle is visible at the following falling edge
  task automatic issue(input logic [31:0] w);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    instr_i    = w;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic set_flags(input logic [3:0] f);
    @(negedge clk_i);
    flag_we_i = 1'b1;
    flag_d_i  = f;
    @(negedge clk_i);
    flag_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 32'(out_valid_o), 0);
    chk("R1 exec", 32'(exec_o), 0);
    chk("R1 illegal", 32'(illegal_o), 0);
    chk("R1 dest_wr", 32'(dest_wr_o), 0);
    chk("R1 flags", 32'(flags_o), 0);
  endtask

  task automatic t_three_reg;
    issue(mk(4'h0, 6'd11, regs(5'd5, 5'd6, {5'd7, 7'h55})));
    chk("R2 valid", 32'(out_valid_o), 1);
    chk("R3 mode op11", 32'(mode_o), 0);
    chk("R10 class op11", 32'(class_o), 0);
    chk("R4 rd", 32'(rd_o), 5);
    chk("R4 rs1", 32'(rs1_o), 6);
    chk("R4 rs2", 32'(rs2_o), 7);
    chk("R6 imm rrr", imm_o, 0);
    chk("R11 dest_wr", 32'(dest_wr_o), 1);
    chk("R2 opcode", 32'(opcode_o), 11);
  endtask

  task automatic t_reg_imm;
    issue(mk(4'h0, 6'd12, regs(5'd3, 5'd4, 12'hFFF)));
    chk("R3 mode op12", 32'(mode_o), 1);
    chk("R5 imm -1", imm_o, 32'hFFFF_FFFF);
    chk("R4 rs2 ri", 32'(rs2_o), 0);
    issue(mk(4'h0, 6'd1, regs(5'd3, 5'd4, 12'h7FF)));
    chk("R3 mode op1", 32'(mode_o), 1);
    chk("R5 imm pos", imm_o, 32'h0000_07FF);
    issue(mk(4'h0, 6'd8, regs(5'd1, 5'd2, {5'd9, 7'h0})));
    chk("R3 mode op8", 32'(mode_o), 0);
    issue(mk(4'h0, 6'd16, regs(5'd1, 5'd2, 12'h800)));
    chk("R3 mode op16", 32'(mode_o), 1);
    chk("R5 imm min", imm_o, 32'hFFFF_F800);
  endtask

  task automatic t_memory;
    issue(mk(4'h0, 6'd17, regs(5'd8, 5'd30, 12'h800)));
    chk("R3 mode op17", 32'(mode_o), 2);
    chk("R10 class load", 32'(class_o), 1);
    chk("R6 zext", imm_o, 32'h0000_0800);
    chk("R4 rs2 bo", 32'(rs2_o), 0);
    chk("R11 load writes", 32'(dest_wr_o), 1);
    issue(mk(4'h0, 6'd24, regs(5'd9, 5'd10, {5'd11, 7'h7F})));
    chk("R3 mode op24", 32'(mode_o), 3);
    chk("R10 class store", 32'(class_o), 2);
    chk("R4 index", 32'(rs2_o), 11);
    chk("R6 imm bi", imm_o, 0);
    chk("R11 store no write", 32'(dest_wr_o), 0);
    issue(mk(4'h0, 6'd22, regs(5'd1, 5'd2, {5'd3, 7'h0})));
    chk("R10 class op22", 32'(class_o), 1);
    issue(mk(4'h0, 6'd23, regs(5'd1, 5'd2, 12'h0)));
    chk("R10 class op23", 32'(class_o), 2);
  endtask

  task automatic t_flow;
    issue(mk(4'h0, 6'd29, 22'h200000));
    chk("R3 mode op29", 32'(mode_o), 4);
    chk("R10 class branch", 32'(class_o), 3);
    chk("R5 long neg", imm_o, 32'hFFE0_0000);
    chk("R4 rd imm", 32'(rd_o), 0);
    chk("R4 rs1 imm", 32'(rs1_o), 0);
    issue(mk(4'h0, 6'd31, 22'h1FFFFC));
    chk("R10 class op31", 32'(class_o), 4);
    chk("R5 long pos", imm_o, 32'h001F_FFFC);
    issue(mk(4'h0, 6'd30, regs(5'd12, 5'd13, {5'd14, 7'h0})));
    chk("R3 mode op30", 32'(mode_o), 0);
    chk("R4 jmp rd", 32'(rd_o), 0);
    chk("R4 jmp rs1", 32'(rs1_o), 13);
    chk("R4 jmp rs2", 32'(rs2_o), 0);
    issue(mk(4'h0, 6'd32, 22'h3ABCDE));
    chk("R10 class trap", 32'(class_o), 5);
    issue(mk(4'h0, 6'd10, regs(5'd2, 5'd3, {5'd4, 7'h0})));
    chk("R3 mode op10", 32'(mode_o), 0);
    chk("R4 not rs2", 32'(rs2_o), 0);
  endtask

  task automatic t_illegal;
    issue(mk(4'h0, 6'd33, regs(5'd2, 5'd3, 12'h0)));
    chk("R8 illegal 33", 32'(illegal_o), 1);
    chk("R8 exec 33", 32'(exec_o), 0);
    chk("R8 mode 33", 32'(mode_o), 7);
    chk("R8 class 33", 32'(class_o), 7);
    chk("R11 no write", 32'(dest_wr_o), 0);
    issue(mk(4'h0, 6'd63, 22'h0));
    chk("R8 illegal 63", 32'(illegal_o), 1);
    issue(mk(4'h0, 6'd32, 22'h0));
    chk("R8 legal 32", 32'(illegal_o), 0);
  endtask

  task automatic t_predicate;
    set_flags(4'b0101);
    chk("R9 flags loaded", 32'(flags_o), 32'h5);
    issue(mk(4'b0101, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R7 N&P pass", 32'(exec_o), 1);
    issue(mk(4'b0100, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R7 N pass", 32'(exec_o), 1);
    issue(mk(4'b0110, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R7 N&Z fail", 32'(exec_o), 0);
    chk("R11 blocked", 32'(dest_wr_o), 0);
    chk("R7 still valid", 32'(out_valid_o), 1);
    issue(mk(4'b1111, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R7 all fail", 32'(exec_o), 0);
    issue(mk(4'b0000, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R7 empty mask", 32'(exec_o), 1);
    issue(mk(4'b1000, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R7 C fail", 32'(exec_o), 0);
  endtask

  task automatic t_same_edge;
    set_flags(4'b0000);
    @(negedge clk_i);
    flag_we_i  = 1'b1;
    flag_d_i   = 4'b1000;
    in_valid_i = 1'b1;
    instr_i    = mk(4'b1000, 6'd11, regs(5'd1, 5'd2, 12'h0));
    @(negedge clk_i);
    flag_we_i  = 1'b0;
    in_valid_i = 1'b0;
    chk("R9 old flags used", 32'(exec_o), 0);
    chk("R9 new flags", 32'(flags_o), 32'h8);
    issue(mk(4'b1000, 6'd11, regs(5'd1, 5'd2, 12'h0)));
    chk("R9 C now set", 32'(exec_o), 1);
    @(negedge clk_i);
    chk("R9 hold", 32'(flags_o), 32'h8);
  endtask

  task automatic t_idle;
    issue(mk(4'h0, 6'd11, regs(5'd5, 5'd6, 12'h0)));
    chk("R2 pre-idle exec", 32'(exec_o), 1);
    @(negedge clk_i);
    chk("R2 idle valid", 32'(out_valid_o), 0);
    chk("R2 idle exec", 32'(exec_o), 0);
    chk("R2 idle dest_wr", 32'(dest_wr_o), 0);
  endtask

  task automatic t_discard;
    issue(mk(4'h0, 6'd11, regs(5'd0, 5'd6, {5'd7, 7'h0})));
    chk("R11 discard exec", 32'(exec_o), 1);
    chk("R11 discard no write", 32'(dest_wr_o), 0);
    issue(mk(4'h0, 6'd11, regs(5'd31, 5'd6, {5'd7, 7'h0})));
    chk("R11 pc dest", 32'(dest_wr_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_three_reg;
    t_reg_imm;
    t_memory;
    t_flow;
    t_illegal;
    t_predicate;
    t_same_edge;
    t_idle;
    t_discard;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule